// File: doc/BRIEF.md
# Display Channel I2C Register Target

This block is an I2C target on a display data channel. It lets a host reach a small bank of 8-bit registers through a one-byte subaddress. SCL and SDA arrive as open-drain lines. The block samples them with its own system clock, passes them through a two-flop synchroniser and a glitch filter, and then looks for start conditions, stop conditions and clock edges. The block drives SDA only by pulling it low, through `sdaOe`.

In a write transaction, the first byte after the target address loads the subaddress, and every later byte is stored at the current subaddress. In a read transaction, bytes are returned from the current subaddress. The subaddress steps forward by one after every data byte in either direction, so a host can move a block of registers in one burst. The register set contains:
- a writable 40-bit key vector that the consuming engine sees on `keyVec`;
- a fixed capability byte;
- a status word taken from an input port;
- fixed device and revision identifiers.

A strap input chooses which of two 7-bit target addresses the block answers to.

Top module: `ddc_reg_target`

## Requirements
- R1: After reset, SDA is released (`sdaOe` low), all key bytes are 0x00 and the subaddress is 0x00.
- R2: The block acknowledges only the target address picked by `addrSel` (0 selects 0x3A, 1 selects 0x3B). Any other address gets no acknowledge, and the rest of that transaction is ignored.
- R3: In a write, the first byte after the address loads the subaddress. Later bytes written to 0x10..0x14 set key byte 0..4, which is `keyVec[8i+7:8i]` for byte i, least significant byte at 0x10.
- R4: The subaddress goes up by one after every data byte, in writes and in reads. It is kept across a stop, so a later read with no subaddress byte continues from it.
- R5: Data bytes written to read-only or unmapped subaddresses are acknowledged and change nothing.
- R6: Subaddress 0x40 reads the capability byte 0x10. Bit 4 (400 kHz capable) is 1, and bit 6 (repeater) and bit 5 (list ready) are 0.
- R7: Subaddress 0x41 reads `statusIn[7:0]` and 0x42 reads `statusIn[15:8]`, both sampled at the time of the read.
- R8: Subaddresses 0xC2 and 0xC3 read device identifier 0x0501, low byte first (0x01, then 0x05), and 0xC4 reads revision 0x01. All other unmapped subaddresses read 0x00.
- R9: A repeated start is accepted. A subaddress write followed by a repeated start and a read returns data from the new subaddress.
- R10: When the host does not acknowledge a read byte, the block stops transmitting and keeps SDA released until the next start.
- R11: Pulses on SCL shorter than `FILT_LEN` system clocks are filtered out and do not count as bit clocks.
- R12: The block releases SDA while it receives bits and during the host's acknowledge slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Sampled SCL line level |
| sdaIn | input | 1 | Sampled SDA line level |
| sdaOe | output | 1 | High pulls SDA low |
| addrSel | input | 1 | Strap that selects one of the two target addresses |
| statusIn | input | 16 | Status word returned at subaddresses 0x41/0x42 |
| keyVec | output | 40 | Contents of the key vector registers |

## Verification
On every cycle, the assertions check that SDA is released while the block is idle, receiving bits, or waiting in the host's acknowledge slot. They also check three things on every cycle:
- a subaddress byte lands in the pointer;
- each data byte advances the pointer by exactly one;
- writes outside the key range leave the key untouched;

and that the filtered lines only move after the synchronised input has held steady.

Only the bench scenarios can show the remaining behaviours:
- the contents of the register map;
- address matching under both strap settings;
- burst continuity across a stop;
- the repeated-start read;
- the end of a read on a not-acknowledge;
- rejection of short SCL glitches in the middle of a byte.

// File: rtl/ddc_reg_pkg.sv
package ddc_reg_pkg;

  typedef struct packed {
    logic       loadSub;
    logic       wrData;
    logic       incSub;
    logic [7:0] byteVal;
  } regStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK
  } busState_t;

  typedef enum logic [1:0] {
    K_ADDR,
    K_SUB,
    K_DATA
  } byteKind_t;

endpackage

// File: rtl/ddc_line_filter.sv
module ddc_line_filter #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic cleanOut
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [1:0]    syncQ;
  logic [CW-1:0] runCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ    <= 2'b11;
      cleanOut <= 1'b1;
      runCnt   <= '0;
    end else begin
      syncQ <= {syncQ[0], rawIn};
      if (syncQ[1] == cleanOut) begin
        runCnt <= '0;
      end else if (runCnt == CW'(FILT_LEN - 1)) begin
        cleanOut <= syncQ[1];
        runCnt   <= '0;
      end else begin
        runCnt <= runCnt + CW'(1);
      end
    end
  end

  // R11: a filtered edge only follows a synchroniser value that held for two samples
  a_r11_filter_steady: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cleanOut) |-> ($past(syncQ[1]) == $past(syncQ[1], 2)));

endmodule

// File: rtl/ddc_bus_ctrl.sv
module ddc_bus_ctrl
  import ddc_reg_pkg::*;
#(
  parameter int FILT_LEN = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [6:0] myAddr,
  input  logic [7:0] rdByte,
  output regStrobe_t strobe,
  output logic       sdaOe
);
  logic sclF, sdaF, sclD, sdaD;
  logic sclRise, sclFall, startSeen, stopSeen;
  busState_t  state;
  byteKind_t  kind;
  logic [3:0] bitCnt;
  logic [7:0] rxShift, txShift;
  logic       readMode, masterNack;

  ddc_line_filter #(.FILT_LEN(FILT_LEN)) uSclFilt (
    .clk(clk), .rstN(rstN), .rawIn(sclIn), .cleanOut(sclF));
  ddc_line_filter #(.FILT_LEN(FILT_LEN)) uSdaFilt (
    .clk(clk), .rstN(rstN), .rawIn(sdaIn), .cleanOut(sdaF));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclD <= 1'b1;
      sdaD <= 1'b1;
    end else begin
      sclD <= sclF;
      sdaD <= sdaF;
    end
  end

  assign sclRise   = sclF & ~sclD;
  assign sclFall   = ~sclF & sclD;
  assign startSeen = sclF & sclD & sdaD & ~sdaF;
  assign stopSeen  = sclF & sclD & ~sdaD & sdaF;

  always_comb begin
    strobe         = '0;
    strobe.byteVal = rxShift;
    if (state == ST_RX && sclFall && bitCnt == 4'd8) begin
      strobe.loadSub = (kind == K_SUB);
      strobe.wrData  = (kind == K_DATA);
    end
    if (state == ST_TX && sclFall && bitCnt == 4'd8) strobe.incSub = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      kind       <= K_ADDR;
      bitCnt     <= '0;
      rxShift    <= '0;
      txShift    <= '0;
      readMode   <= 1'b0;
      masterNack <= 1'b0;
      sdaOe      <= 1'b0;
    end else if (startSeen) begin
      state  <= ST_RX;
      kind   <= K_ADDR;
      bitCnt <= '0;
      sdaOe  <= 1'b0;
    end else if (stopSeen) begin
      state <= ST_IDLE;
      sdaOe <= 1'b0;
    end else begin
      case (state)
        ST_RX: begin
          if (sclRise) begin
            rxShift <= {rxShift[6:0], sdaF};
            bitCnt  <= bitCnt + 4'd1;
          end else if (sclFall && bitCnt == 4'd8) begin
            if (kind == K_ADDR && rxShift[7:1] != myAddr) begin
              state <= ST_IDLE;
            end else begin
              state <= ST_ACK;
              sdaOe <= 1'b1;
              if (kind == K_ADDR) readMode <= rxShift[0];
            end
          end
        end
        ST_ACK: begin
          if (sclFall) begin
            bitCnt <= '0;
            if (kind == K_ADDR && readMode) begin
              state   <= ST_TX;
              txShift <= rdByte;
              sdaOe   <= ~rdByte[7];
            end else begin
              state <= ST_RX;
              sdaOe <= 1'b0;
              kind  <= (kind == K_ADDR) ? K_SUB : K_DATA;
            end
          end
        end
        ST_TX: begin
          if (sclRise) begin
            bitCnt <= bitCnt + 4'd1;
          end else if (sclFall) begin
            if (bitCnt == 4'd8) begin
              state <= ST_MACK;
              sdaOe <= 1'b0;
            end else begin
              txShift <= {txShift[6:0], 1'b0};
              sdaOe   <= ~txShift[6];
            end
          end
        end
        ST_MACK: begin
          if (sclRise) begin
            masterNack <= sdaF;
          end else if (sclFall) begin
            if (!masterNack) begin
              state   <= ST_TX;
              bitCnt  <= '0;
              txShift <= rdByte;
              sdaOe   <= ~rdByte[7];
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: begin
          state <= ST_IDLE;
          sdaOe <= 1'b0;
        end
      endcase
    end
  end

  // R10: idle target never holds the data line
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> !sdaOe);
  // R12: line released while receiving bits
  a_r12_rx_release: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RX) |-> !sdaOe);
  // R12: line released during the host acknowledge slot
  a_r12_mack_release: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_MACK) |-> !sdaOe);

endmodule

// File: rtl/ddc_reg_data.sv
module ddc_reg_data
  import ddc_reg_pkg::*;
#(
  parameter int          KEY_BYTES  = 5,
  parameter logic [7:0]  KEY_BASE   = 8'h10,
  parameter logic [7:0]  CAPS_SUB   = 8'h40,
  parameter logic [7:0]  CAPS_VALUE = 8'h10,
  parameter logic [7:0]  STATUS_SUB = 8'h41,
  parameter logic [7:0]  ID_SUB     = 8'hC2,
  parameter logic [15:0] DEV_ID     = 16'h0501,
  parameter logic [7:0]  REV_ID     = 8'h01
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  regStrobe_t             strobe,
  input  logic [15:0]            statusIn,
  output logic [7:0]             rdByte,
  output logic [8*KEY_BYTES-1:0] keyVec
);
  logic [7:0] subPtr;
  logic [7:0] keyMem [KEY_BYTES];
  logic       keyHit;

  always_comb begin
    keyHit = 1'b0;
    for (int i = 0; i < KEY_BYTES; i++)
      if (subPtr == 8'(int'(KEY_BASE) + i)) keyHit = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      subPtr <= '0;
      for (int i = 0; i < KEY_BYTES; i++) keyMem[i] <= '0;
    end else begin
      if (strobe.loadSub) begin
        subPtr <= strobe.byteVal;
      end else if (strobe.wrData) begin
        for (int i = 0; i < KEY_BYTES; i++)
          if (subPtr == 8'(int'(KEY_BASE) + i)) keyMem[i] <= strobe.byteVal;
        subPtr <= subPtr + 8'd1;
      end else if (strobe.incSub) begin
        subPtr <= subPtr + 8'd1;
      end
    end
  end

  for (genvar g = 0; g < KEY_BYTES; g++) begin : gKeyOut
    assign keyVec[8*g +: 8] = keyMem[g];
  end

  always_comb begin
    rdByte = 8'h00;
    for (int i = 0; i < KEY_BYTES; i++)
      if (subPtr == 8'(int'(KEY_BASE) + i)) rdByte = keyMem[i];
    if (subPtr == CAPS_SUB)                rdByte = CAPS_VALUE;
    if (subPtr == STATUS_SUB)              rdByte = statusIn[7:0];
    if (subPtr == STATUS_SUB + 8'd1)       rdByte = statusIn[15:8];
    if (subPtr == ID_SUB)                  rdByte = DEV_ID[7:0];
    if (subPtr == ID_SUB + 8'd1)           rdByte = DEV_ID[15:8];
    if (subPtr == ID_SUB + 8'd2)           rdByte = REV_ID;
  end

  // R3: subaddress byte lands in the pointer
  a_r3_load_sub: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadSub |=> (subPtr == $past(strobe.byteVal)));
  // R4: each data byte moves the pointer by one
  a_r4_auto_inc: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrData || strobe.incSub) |=> (subPtr == $past(subPtr) + 8'd1));
  // R5: writes outside the key range leave the key alone
  a_r5_ro_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrData && !keyHit) |=> $stable(keyVec));

endmodule

// File: rtl/ddc_reg_target.sv
module ddc_reg_target #(
  parameter logic [6:0] ADDR_LO   = 7'h3A,
  parameter logic [6:0] ADDR_HI   = 7'h3B,
  parameter int         FILT_LEN  = 4,
  parameter int         KEY_BYTES = 5
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   sclIn,
  input  logic                   sdaIn,
  output logic                   sdaOe,
  input  logic                   addrSel,
  input  logic [15:0]            statusIn,
  output logic [8*KEY_BYTES-1:0] keyVec
);
  import ddc_reg_pkg::*;

  regStrobe_t strobe;
  logic [7:0] rdByte;
  logic [6:0] myAddr;

  assign myAddr = addrSel ? ADDR_HI : ADDR_LO;

  ddc_bus_ctrl #(.FILT_LEN(FILT_LEN)) uCtrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .myAddr(myAddr), .rdByte(rdByte), .strobe(strobe), .sdaOe(sdaOe));

  ddc_reg_data #(.KEY_BYTES(KEY_BYTES)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .statusIn(statusIn),
    .rdByte(rdByte), .keyVec(keyVec));

endmodule

// File: tb/ddc_reg_target_test.sv
module ddc_reg_target_test;
  localparam int Q = 10;

  typedef struct packed {
    logic [7:0] sub;
    logic [7:0] exp;
  } rdVec_t;

  // R3 key bytes, R6 capability, R7 status, R8 identifiers and unmapped, R9 repeated start
  localparam rdVec_t RD_TABLE [13] = '{
    '{8'h10, 8'h11}, '{8'h11, 8'h22}, '{8'h12, 8'h33}, '{8'h13, 8'h44},
    '{8'h14, 8'h55}, '{8'h40, 8'h10}, '{8'h41, 8'hEF}, '{8'h42, 8'hBE},
    '{8'hC2, 8'h01}, '{8'hC3, 8'h05}, '{8'hC4, 8'h01}, '{8'h15, 8'h00},
    '{8'h00, 8'h00}
  };

  logic clk = 0;
  logic rstN = 0;
  logic sclM = 1, sdaM = 1;
  logic addrSel = 0;
  logic [15:0] statusIn = 16'hBEEF;
  logic sdaOe;
  logic [39:0] keyVec;
  wire  sdaLine = sdaM & ~sdaOe;

  int checks = 0, errors = 0;
  logic [6:0] devAddr = 7'h3A;
  logic [7:0] rdBuf [8];
  logic [7:0] wrBuf [8];
  logic ackBit, quietBit;

  always #10 clk = ~clk;

  ddc_reg_target uut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine), .sdaOe(sdaOe),
    .addrSel(addrSel), .statusIn(statusIn), .keyVec(keyVec));

  task automatic waitQ(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic busStart();
    sdaM = 1; waitQ(Q); sclM = 1; waitQ(2*Q);
    sdaM = 0; waitQ(2*Q); sclM = 0; waitQ(Q);
  endtask

  task automatic busStop();
    sdaM = 0; waitQ(Q); sclM = 1; waitQ(2*Q); sdaM = 1; waitQ(2*Q);
  endtask

  task automatic sendByte(input logic [7:0] b, input logic glitch, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i];
      waitQ(4);
      if (glitch) begin sclM = 1; waitQ(2); sclM = 0; end
      else waitQ(2);
      waitQ(Q - 6);
      sclM = 1; waitQ(2*Q); sclM = 0; waitQ(Q);
    end
    sdaM = 1; waitQ(Q); sclM = 1; waitQ(Q);
    acked = !sdaLine;
    waitQ(Q); sclM = 0; waitQ(Q);
  endtask

  task automatic recvByte(input logic nack, output logic [7:0] b, output logic quiet);
    sdaM = 1;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      waitQ(Q); sclM = 1; waitQ(Q);
      b = {b[6:0], sdaLine};
      waitQ(Q); sclM = 0; waitQ(Q);
    end
    sdaM = nack;
    waitQ(Q); sclM = 1; waitQ(Q);
    quiet = !sdaOe;
    waitQ(Q); sclM = 0; waitQ(Q);
    sdaM = 1;
  endtask

  task automatic writeBurst(input logic [7:0] sub, input int n);
    logic a;
    busStart();
    sendByte({devAddr, 1'b0}, 1'b0, a);
    sendByte(sub, 1'b0, a);
    for (int i = 0; i < n; i++) sendByte(wrBuf[i], 1'b0, a);
    busStop();
  endtask

  task automatic readBurst(input logic [7:0] sub, input int n);
    logic a, q;
    busStart();
    sendByte({devAddr, 1'b0}, 1'b0, a);
    sendByte(sub, 1'b0, a);
    busStart();
    sendByte({devAddr, 1'b1}, 1'b0, a);
    for (int i = 0; i < n; i++) recvByte(i == n - 1, rdBuf[i], q);
    busStop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    waitQ(5);
    // R1 reset state
    check("R1 sdaOe after reset", 64'(sdaOe), 64'h0);
    check("R1 key after reset", 64'(keyVec), 64'h0);
    rstN = 1;
    waitQ(10);

    // R2 wrong address is not acknowledged
    busStart();
    sendByte({7'h3B, 1'b0}, 1'b0, ackBit);
    busStop();
    check("R2 foreign address ack", 64'(ackBit), 64'h0);
    // R2 strap selects the other address
    addrSel = 1; devAddr = 7'h3B;
    wrBuf[0] = 8'hA5;
    writeBurst(8'h10, 1);
    check("R2 strap high write", 64'(keyVec[7:0]), 64'hA5);
    addrSel = 0; devAddr = 7'h3A;

    // R3 R4 burst write of the key, least significant byte first
    wrBuf[0] = 8'h11; wrBuf[1] = 8'h22; wrBuf[2] = 8'h33; wrBuf[3] = 8'h44; wrBuf[4] = 8'h55;
    writeBurst(8'h10, 5);
    check("R3 R4 key burst", 64'(keyVec), 64'h5544332211);

    // R5 burst crossing past the key end, then read-only targets
    wrBuf[0] = 8'h66; wrBuf[1] = 8'h77;
    writeBurst(8'h14, 2);
    check("R5 write past key end", 64'(keyVec), 64'h6644332211);
    busStart();
    sendByte({devAddr, 1'b0}, 1'b0, ackBit);
    sendByte(8'h40, 1'b0, ackBit);
    sendByte(8'hFF, 1'b0, ackBit);
    busStop();
    check("R5 read-only write acked", 64'(ackBit), 64'h1);
    wrBuf[0] = 8'hEE;
    writeBurst(8'hC4, 1);
    check("R5 key unchanged", 64'(keyVec), 64'h6644332211);
    wrBuf[0] = 8'h55;
    writeBurst(8'h14, 1);

    // table: single reads through a repeated start
    foreach (RD_TABLE[k]) begin
      readBurst(RD_TABLE[k].sub, 1);
      check($sformatf("R3/R6/R7/R8/R9 table sub %0h", RD_TABLE[k].sub),
            64'(rdBuf[0]), 64'(RD_TABLE[k].exp));
    end

    // R4 R8 burst read of identifiers
    readBurst(8'hC2, 3);
    check("R4 R8 burst id lo", 64'(rdBuf[0]), 64'h01);
    check("R4 R8 burst id hi", 64'(rdBuf[1]), 64'h05);
    check("R4 R8 burst rev", 64'(rdBuf[2]), 64'h01);

    // R4 pointer kept across stop
    busStart();
    sendByte({devAddr, 1'b0}, 1'b0, ackBit);
    sendByte(8'h12, 1'b0, ackBit);
    busStop();
    busStart();
    sendByte({devAddr, 1'b1}, 1'b0, ackBit);
    recvByte(1'b0, rdBuf[0], quietBit);
    check("R12 quiet in host ack slot", 64'(quietBit), 64'h1);
    recvByte(1'b1, rdBuf[1], quietBit);
    busStop();
    check("R4 read after stop", 64'(rdBuf[0]), 64'h33);
    check("R4 read continues", 64'(rdBuf[1]), 64'h44);

    // R10 released after host not-acknowledge
    check("R10 quiet on nack", 64'(quietBit), 64'h1);
    waitQ(40);
    check("R10 idle after nack", 64'(sdaOe), 64'h0);

    // R7 status sampled at read time
    statusIn = 16'h1234;
    readBurst(8'h41, 2);
    check("R7 status low", 64'(rdBuf[0]), 64'h34);
    check("R7 status high", 64'(rdBuf[1]), 64'h12);

    // R11 short SCL glitches during a byte are ignored
    busStart();
    sendByte({devAddr, 1'b0}, 1'b1, ackBit);
    sendByte(8'h11, 1'b1, ackBit);
    sendByte(8'hC3, 1'b1, ackBit);
    busStop();
    check("R11 glitched write", 64'(keyVec[15:8]), 64'hC3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule